// File: doc/BRIEF.md
# Differential Clock Fan-out Enable and Power-Down Controller

This block is the digital control for a one-to-many differential clock fan-out stage. It oversamples a true/complement reference pair with a free-running local clock and decides, for every output pair and for the feedback pair, whether that pair passes the reference or is held with both legs low. An asynchronous output-enable pin gates the ordinary output pairs. A select strap can exempt one chosen pair from that enable so it runs like the feedback pair. A bypass strap turns the frequency-locking loop off and lets the outputs track the reference directly.

When both reference legs read low for a programmable number of local-clock cycles, the block drops into a low-power state. In that state every pair and the loop-enable output are off, and the reference lines may float. When a valid differential reference returns, the block switches the loop back on and holds all outputs low for a fixed stabilization count before it releases them. The loop, the analog receivers and the drivers lie outside this block. A two-bit mode output reports which of the three states the block is in. There is no streaming data path, so every pin is plain control or status.

Top module: `fanout_ctrl`

## Requirements
- R1: While the mode is active and `all_gated` is high, `oe_a` low drives both legs of every output pair low, and `oe_a` high lets every pair toggle.
- R2: While the mode is active, the feedback pair toggles whatever `oe_a` is, and `pll_en` is high when `pll_bypass` is low.
- R3: With `all_gated` low, pair FREE_PAIR (default 7) toggles in the active mode even when `oe_a` is low, while the other pairs stay low.
- R4: An enabled pair drives its complement leg as the inverse of its true leg, and both follow the reference two local-clock cycles late. A disabled pair drives both legs low.
- R5: Both reference legs low for LOW_DET_CYC consecutive synchronized cycles enter the powered-down mode. A shorter both-low interval leaves the mode unchanged.
- R6: In the powered-down mode every output leg, both feedback legs and `pll_en` are low, whatever `oe_a` or the reference lines do.
- R7: Both reference legs high is reserved. It never starts power-down from the active mode and never wakes the block from the powered-down mode.
- R8: In the powered-down mode with `pll_bypass` low, a valid differential reference starts relocking. The mode reads relocking for exactly RELOCK_CYC cycles with all pairs and feedback low, then reads active.
- R9: With `pll_bypass` high, `pll_en` stays low. Wake-up goes from powered-down straight to active with no relocking cycles, and R1 to R3 still hold.
- R10: An enable change on a pair takes effect only while the synchronized true reference is low, so every high pulse on a true leg lasts a full reference half period.
- R11: The `mode` encoding is 2'b00 active, 2'b01 powered-down, 2'b10 relocking. Reset puts the block into powered-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Active-low reset |
| ref_t | input | 1 | Reference clock, true leg (asynchronous) |
| ref_c | input | 1 | Reference clock, complement leg (asynchronous) |
| oe_a | input | 1 | Output enable, asynchronous, active high |
| all_gated | input | 1 | Select strap: high gates every pair, low exempts FREE_PAIR |
| pll_bypass | input | 1 | Bypass strap: high turns the loop off |
| clk_t | output | NUM_PAIRS | Output pairs, true legs |
| clk_c | output | NUM_PAIRS | Output pairs, complement legs |
| fb_t | output | 1 | Feedback pair, true leg |
| fb_c | output | 1 | Feedback pair, complement leg |
| pll_en | output | 1 | Loop enable |
| mode | output | 2 | 00 active, 01 powered-down, 10 relocking |

## Verification
The bench builds the block with LOW_DET_CYC = 6 and RELOCK_CYC = 40, and keeps the default ten pairs with pair 7 exempt. The short relock count lets the bench count every relocking cycle exactly, on both the loop and the bypass wake-up paths. It also leaves room to walk the whole enable, select, bypass and input-state table within a short run. A six-cycle detect window sits above the bench's two-cycle both-low glitch, so both the filtered case and the accepted case are reached.

// File: rtl/fo_pkg.sv
package fo_pkg;
  typedef enum logic [1:0] {
    FO_ACTIVE = 2'b00,
    FO_PDOWN  = 2'b01,
    FO_RELOCK = 2'b10
  } fo_mode_e;
endpackage

// File: rtl/fo_sync.sv
module fo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fo_pwr_fsm.sv
module fo_pwr_fsm
  import fo_pkg::*;
#(
  parameter int LOW_DET_CYC = 4,
  parameter int RELOCK_CYC  = 750
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     t_s,
  input  logic     c_s,
  input  logic     byp_s,
  output fo_mode_e state
);
  localparam int LCW = $clog2(LOW_DET_CYC + 1);
  localparam int RCW = $clog2(RELOCK_CYC + 1);

  logic [LCW-1:0] low_cnt;
  logic [RCW-1:0] rl_cnt;
  logic both_low, pd_hit, wake, rl_done;

  assign both_low = !t_s && !c_s;
  assign pd_hit   = both_low && (low_cnt == LCW'(LOW_DET_CYC - 1));
  assign wake     = t_s ^ c_s;
  assign rl_done  = (rl_cnt == RCW'(RELOCK_CYC - 1));

  // consecutive both-low filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              low_cnt <= '0;
    else if (!both_low || state == FO_PDOWN) low_cnt <= '0;
    else if (!pd_hit)                        low_cnt <= low_cnt + 1'b1;
  end

  // stabilization timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rl_cnt <= '0;
    else if (state != FO_RELOCK) rl_cnt <= '0;
    else                         rl_cnt <= rl_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FO_PDOWN;
    else begin
      case (state)
        FO_ACTIVE: if (pd_hit) state <= FO_PDOWN;
        FO_PDOWN:  if (wake)   state <= byp_s ? FO_ACTIVE : FO_RELOCK;
        FO_RELOCK: begin
          if (pd_hit)       state <= FO_PDOWN;
          else if (rl_done) state <= FO_ACTIVE;
        end
        default:   state <= FO_PDOWN;
      endcase
    end
  end
endmodule

// File: rtl/fo_lane.sv
module fo_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic t_s,
  input  logic c_s,
  input  logic want,
  input  logic kill,
  output logic o_t,
  output logic o_c
);
  logic en_q;

  // enable moves only while the true reference is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (kill) en_q <= 1'b0;
    else if (!t_s) en_q <= want;
  end

  assign o_t = en_q && !kill && t_s;
  assign o_c = en_q && !kill && c_s;
endmodule

// File: rtl/fanout_ctrl.sv
module fanout_ctrl
  import fo_pkg::*;
#(
  parameter int NUM_PAIRS   = 10,
  parameter int FREE_PAIR   = 7,
  parameter int LOW_DET_CYC = 4,
  parameter int RELOCK_CYC  = 750
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_t,
  input  logic                 ref_c,
  input  logic                 oe_a,
  input  logic                 all_gated,
  input  logic                 pll_bypass,
  output logic [NUM_PAIRS-1:0] clk_t,
  output logic [NUM_PAIRS-1:0] clk_c,
  output logic                 fb_t,
  output logic                 fb_c,
  output logic                 pll_en,
  output logic [1:0]           mode
);
  localparam int LANES = NUM_PAIRS + 1;

  logic     t_s, c_s, oe_s, all_s, byp_s;
  logic     run, pd;
  fo_mode_e state;
  logic [LANES-1:0] lane_t, lane_c;

  fo_sync #(.W(5)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ref_t, ref_c, oe_a, all_gated, pll_bypass}),
    .q    ({t_s, c_s, oe_s, all_s, byp_s})
  );

  fo_pwr_fsm #(.LOW_DET_CYC(LOW_DET_CYC), .RELOCK_CYC(RELOCK_CYC)) u_fsm (
    .clk  (clk),
    .rst_n(rst_n),
    .t_s  (t_s),
    .c_s  (c_s),
    .byp_s(byp_s),
    .state(state)
  );

  assign run = (state == FO_ACTIVE);
  assign pd  = (state == FO_PDOWN);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic want;
    if (l == NUM_PAIRS) begin : g_fb
      assign want = run;
    end else if (l == FREE_PAIR) begin : g_free
      assign want = run && (oe_s || !all_s);
    end else begin : g_norm
      assign want = run && oe_s;
    end
    fo_lane u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .t_s  (t_s),
      .c_s  (c_s),
      .want (want),
      .kill (pd),
      .o_t  (lane_t[l]),
      .o_c  (lane_c[l])
    );
  end

  assign clk_t  = lane_t[NUM_PAIRS-1:0];
  assign clk_c  = lane_c[NUM_PAIRS-1:0];
  assign fb_t   = lane_t[NUM_PAIRS];
  assign fb_c   = lane_c[NUM_PAIRS];
  assign pll_en = !pd && !byp_s;
  assign mode   = state;
endmodule

// File: rtl/fanout_ctrl_chk.sv
module fanout_ctrl_chk #(
  parameter int NUM_PAIRS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 t_s,
  input logic                 byp_s,
  input logic [NUM_PAIRS-1:0] clk_t,
  input logic [NUM_PAIRS-1:0] clk_c,
  input logic                 fb_t,
  input logic                 fb_c,
  input logic                 pll_en,
  input logic [1:0]           mode
);
  a_r6_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (clk_t == '0 && clk_c == '0 && !fb_t && !fb_c && !pll_en));

  a_r8_relock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (clk_t == '0 && clk_c == '0 && !fb_t && !fb_c));

  a_r9_bypass_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
    byp_s |-> !pll_en);

  a_r9_bypass_no_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && byp_s) |=> (mode != 2'b10));

  a_r11_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  a_r10_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    (|({fb_t, clk_t} & ~$past({fb_t, clk_t}))) |-> (t_s && !$past(t_s)));
endmodule

bind fanout_ctrl fanout_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .t_s   (t_s),
  .byp_s (byp_s),
  .clk_t (clk_t),
  .clk_c (clk_c),
  .fb_t  (fb_t),
  .fb_c  (fb_c),
  .pll_en(pll_en),
  .mode  (mode)
);

// File: tb/test_fanout_ctrl.sv
module test_fanout_ctrl;
  localparam int NP     = 10;
  localparam int FREE   = 7;
  localparam int LOWDET = 6;
  localparam int RELOCK = 40;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_t = 1'b0, ref_c = 1'b0;
  logic oe_a = 1'b1, all_gated = 1'b1, pll_bypass = 1'b0;
  logic [NP-1:0] clk_t, clk_c;
  logic fb_t, fb_c, pll_en;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rmode = 1;   // 0 clock, 1 both low, 2 both high
  int phc = 0;
  logic ph = 1'b0;
  logic [NP:0] diff_ok, zero_ok, seen_hi;

  always #10 clk = ~clk;

  fanout_ctrl #(.NUM_PAIRS(NP), .FREE_PAIR(FREE), .LOW_DET_CYC(LOWDET), .RELOCK_CYC(RELOCK))
    i_fanout_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_t(ref_t), .ref_c(ref_c), .oe_a(oe_a),
      .all_gated(all_gated), .pll_bypass(pll_bypass), .clk_t(clk_t), .clk_c(clk_c),
      .fb_t(fb_t), .fb_c(fb_c), .pll_en(pll_en), .mode(mode));

  always @(negedge clk) begin
    if (rmode == 0) begin
      phc = phc + 1;
      if (phc == HALF) begin ph = ~ph; phc = 0; end
      ref_t = ph; ref_c = ~ph;
    end else begin
      ref_t = (rmode == 2); ref_c = (rmode == 2);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic lt(input int l);
    return (l < NP) ? clk_t[l] : fb_t;
  endfunction
  function automatic logic lc(input int l);
    return (l < NP) ? clk_c[l] : fb_c;
  endfunction

  task automatic observe(input int n);
    diff_ok = '1; zero_ok = '1; seen_hi = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int l = 0; l <= NP; l++) begin
        if (lt(l)) seen_hi[l] = 1'b1;
        if (lt(l) == lc(l)) diff_ok[l] = 1'b0;
        if (lt(l) || lc(l)) zero_ok[l] = 1'b0;
      end
    end
  endtask

  // lane NP is the feedback pair
  task automatic check_lanes(input logic [NP:0] exp_on, input string tag);
    logic [NP:0] got;
    for (int l = 0; l <= NP; l++) got[l] = diff_ok[l] && seen_hi[l];
    for (int l = 0; l <= NP; l++)
      check(exp_on[l] ? (diff_ok[l] && seen_hi[l]) : zero_ok[l],
            $sformatf("%s lane%0d", tag, l), int'(got), int'(exp_on));
  endtask

  task automatic t_reset;
    cyc(3);
    check(mode == 2'b01, "R11 reset mode", mode, 2'b01);
    check(clk_t == '0 && clk_c == '0 && !fb_t && !fb_c, "R6 reset outputs",
          {clk_t, fb_t}, 0);
    check(pll_en == 1'b0, "R6 reset pll_en", pll_en, 0);
  endtask

  task automatic t_wake_relock;
    int nrl = 0;
    rmode = 0;
    for (int i = 0; i < 400 && mode != 2'b00; i++) begin
      @(negedge clk);
      if (mode == 2'b10) begin
        nrl++;
        check(clk_t == '0 && !fb_t, "R8 outputs low while relocking", {clk_t, fb_t}, 0);
      end
    end
    check(nrl == RELOCK, "R8 relock length", nrl, RELOCK);
    check(mode == 2'b00, "R11 active after relock", mode, 0);
    check(pll_en == 1'b1, "R2 pll_en active", pll_en, 1);
    observe(40);
    check_lanes('1, "R4 all pairs toggle");
  endtask

  task automatic t_oe_all;
    all_gated = 1'b1; oe_a = 1'b0;
    cyc(20); observe(40);
    check_lanes({1'b1, {NP{1'b0}}}, "R1 oe low gates all");
    check(mode == 2'b00 && pll_en, "R2 still active and loop on", {mode, pll_en}, 1);
    oe_a = 1'b1;
    cyc(20); observe(40);
    check_lanes('1, "R1 oe high releases all");
  endtask

  task automatic t_free_pair;
    logic [NP:0] exp;
    all_gated = 1'b0; oe_a = 1'b0;
    cyc(20); observe(40);
    exp = '0; exp[FREE] = 1'b1; exp[NP] = 1'b1;
    check_lanes(exp, "R3 free pair runs with oe low");
    all_gated = 1'b1;
    cyc(20); observe(40);
    check_lanes({1'b1, {NP{1'b0}}}, "R3 strap high gates free pair");
    oe_a = 1'b1; cyc(20);
  endtask

  task automatic t_no_runt;
    int run_len = 0, bad = 0, runs = 0;
    bit in_run = 0, armed = 0;
    for (int k = 0; k < 240; k++) begin
      if (k == 13 || k == 38 || k == 61 || k == 94 || k == 119 || k == 150 || k == 183)
        oe_a = ~oe_a;
      @(negedge clk);
      if (clk_t[0]) begin
        if (!in_run) begin in_run = 1; run_len = 0; end
        run_len++;
      end else begin
        if (in_run && armed) begin runs++; if (run_len != HALF) bad++; end
        in_run = 0; armed = 1;
      end
    end
    oe_a = 1'b1; cyc(20);
    check(bad == 0, "R10 no shortened high pulse", bad, 0);
    check(runs > 5, "R10 pulses observed", runs, 6);
  endtask

  task automatic t_glitch;
    rmode = 1; cyc(2); rmode = 0;
    cyc(20);
    check(mode == 2'b00, "R5 short both-low ignored", mode, 0);
    observe(40);
    check_lanes('1, "R5 outputs run after glitch");
  endtask

  task automatic t_high_active;
    rmode = 2; cyc(30);
    check(mode == 2'b00, "R7 both-high no power-down", mode, 0);
    rmode = 0; cyc(20);
  endtask

  task automatic t_powerdown;
    oe_a = 1'b1;
    rmode = 1; cyc(LOWDET + 10);
    check(mode == 2'b01, "R5 both-low enters power-down", mode, 1);
    observe(20);
    check_lanes('0, "R6 all off in power-down");
    check(pll_en == 1'b0, "R6 pll_en off", pll_en, 0);
    rmode = 2; cyc(10); observe(20);
    check(mode == 2'b01, "R7 both-high does not wake", mode, 1);
    check_lanes('0, "R6 off while inputs high");
  endtask

  task automatic t_bypass;
    int nrl = 0;
    logic [NP:0] exp;
    pll_bypass = 1'b1; rmode = 1; cyc(6);
    rmode = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mode == 2'b10) nrl++;
    end
    check(nrl == 0, "R9 no relock in bypass", nrl, 0);
    check(mode == 2'b00, "R9 active in bypass", mode, 0);
    check(pll_en == 1'b0, "R9 pll_en low in bypass", pll_en, 0);
    observe(40);
    check_lanes('1, "R9 outputs follow in bypass");
    oe_a = 1'b0; all_gated = 1'b0;
    cyc(20); observe(40);
    exp = '0; exp[FREE] = 1'b1; exp[NP] = 1'b1;
    check_lanes(exp, "R9 select rule in bypass");
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_wake_relock();
    t_oe_all();
    t_free_pair();
    t_no_runt();
    t_glitch();
    t_high_active();
    t_powerdown();
    t_bypass();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule